// File: doc/BRIEF.md
# Command and Receive Queue Pair with Interrupt Logic

This block sits between the host register port of a two-wire serial bus controller and its bus sequencer. It holds two first-in first-out queues. The host fills an 11-bit command queue that the sequencer drains, and the sequencer fills an 8-bit receive queue that the host drains. The block also holds the controller's interrupt state: five pending bits, an enable mask, a write-1-to-clear register, a masked status view and one interrupt line. Bus timing and the bus protocol live elsewhere.

The host uses a single-cycle register port addressed by a 4-bit word index. Writes take effect at the next rising clock edge. Read data is combinational from the current address. A read strobe on the receive data word pops the receive queue at that edge. The sequencer has a pop strobe with the head command and an empty flag, a push strobe for received bytes with a full flag, and two pulse inputs that report the end of a transfer and a failed transfer.

Word map: 0 command write (bits [10:0]), 1 receive data read (pops), 2 queue control, 3 queue status, 4 masked interrupt status, 5 interrupt clear, 6 interrupt enable mask. Unmapped words read as zero.

Top module: `xfer_queue_pair`

## Requirements
- R1: Each queue holds 64 entries. `cmd_empty` is high exactly when the command queue holds nothing, and `rx_full` is high exactly when the receive queue holds 64 entries.
- R2: Commands written to word 0 appear on `cmd_head` in the order written, one entry leaving per accepted `cmd_pop`. Bytes pushed with `rx_push` read back from word 1 in push order. Word 1 reads 0 while the receive queue is empty.
- R3: A write to word 2 with bit 0 set empties the receive queue, and one with bit 1 set empties the command queue. Emptying a queue also drops its error flags. In a cycle where a queue is emptied, a push or pop on that queue is discarded. The same write stores the receive almost-full threshold from bits [7:2] and the command almost-empty threshold from bits [13:8]. Word 2 reads those thresholds back in the same positions, and bits 0 and 1 read as 0.
- R4: Word 3 reports: bit 0 receive pop-while-empty, bit 1 receive push-while-full, bit 3 receive queue empty, bit 6 command pop-while-empty, bit 7 command push-while-full, bit 11 command queue full. All other bits read 0.
- R5: A push to a full queue or a pop from an empty queue is dropped and leaves the queue contents unchanged. It sets the matching sticky error flag, which stays set until that queue is emptied through word 2.
- R6: Pending bit 3 (receive threshold) sets on each clock edge where the receive level before the edge is nonzero and at least the receive threshold.
- R7: Pending bit 4 (command low-water) sets on each clock edge where the command level before the edge is at or below the command threshold.
- R8: Pending bit 2 sets on any edge where a dropped push or pop occurs. Pending bit 0 sets on `xfer_done`, and pending bit 1 sets on `xfer_fail`.
- R9: Word 6 holds the enable mask (bits [4:0], 1 enables a source). Word 4 reads the pending bits ANDed with the mask.
- R10: Writing 1 to a bit of word 5 clears that pending bit. A source whose set condition holds in the same cycle keeps its bit set.
- R11: `irq` is high exactly when some pending bit is both set and enabled.
- R12: After reset both queues are empty, all error flags, thresholds, pending bits and mask bits are 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (pops on word 1) |
| host_addr | input | 4 | Host word index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for `host_addr` |
| cmd_pop | input | 1 | Sequencer takes the head command |
| cmd_head | output | 11 | Command at the head of the queue |
| cmd_empty | output | 1 | Command queue empty |
| rx_push | input | 1 | Sequencer pushes a received byte |
| rx_byte | input | 8 | Received byte |
| rx_full | output | 1 | Receive queue full |
| xfer_done | input | 1 | Transfer finished pulse |
| xfer_fail | input | 1 | Transfer failed pulse |
| irq | output | 1 | Interrupt line |

## Verification
A wrong level counter shows at the ports at the next clock edge, as a wrong empty or full flag or status bit. It also shows, one edge later, as a threshold interrupt that fires or fails to fire. A wrong read or write pointer shows as soon as the affected entry reaches the head, because the head command and the receive word are compared in every cycle. A lost or stuck pending, error or mask bit shows in the status words and on `irq` in the cycle after the edge that should have changed it, because the reference model predicts every output in every cycle. The run covers directed corners at both queue ends and a long stretch of random concurrent host and sequencer traffic.

// File: rtl/xfer_queue_pair.sv
module xfer_queue_pair #(
  parameter int DEPTH = 64,
  parameter int CMD_W = 11,
  parameter int DAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [3:0]       host_addr,
  input  logic [31:0]      host_wdata,
  output logic [31:0]      host_rdata,
  input  logic             cmd_pop,
  output logic [CMD_W-1:0] cmd_head,
  output logic             cmd_empty,
  input  logic             rx_push,
  input  logic [DAT_W-1:0] rx_byte,
  output logic             rx_full,
  input  logic             xfer_done,
  input  logic             xfer_fail,
  output logic             irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_N = CW'(DEPTH);
  localparam logic [3:0] A_CMD = 4'd0, A_RXD = 4'd1, A_CTL = 4'd2, A_STA = 4'd3,
                         A_MST = 4'd4, A_CLR = 4'd5, A_MSK = 4'd6;

  logic [CMD_W-1:0] txm [DEPTH];
  logic [DAT_W-1:0] rxm [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp, rx_thr, tx_thr;
  logic [CW-1:0] tx_n, rx_n;
  logic tx_rerr, tx_werr, rx_rerr, rx_werr;
  logic [4:0] pend, mask, setv, clrv;
  logic unused_bits;

  wire wr_cmd = host_wr && host_addr == A_CMD;
  wire rd_rx  = host_rd && host_addr == A_RXD;
  wire wr_ctl = host_wr && host_addr == A_CTL;
  wire tx_clr = wr_ctl && host_wdata[1];
  wire rx_clr = wr_ctl && host_wdata[0];

  wire tx_is_full = tx_n == FULL_N;
  wire tx_is_mt   = tx_n == '0;
  wire rx_is_full = rx_n == FULL_N;
  wire rx_is_mt   = rx_n == '0;

  wire tx_push_ok  = wr_cmd && !tx_is_full && !tx_clr;
  wire tx_push_bad = wr_cmd && tx_is_full && !tx_clr;
  wire tx_pop_ok   = cmd_pop && !tx_is_mt && !tx_clr;
  wire tx_pop_bad  = cmd_pop && tx_is_mt && !tx_clr;
  wire rx_push_ok  = rx_push && !rx_is_full && !rx_clr;
  wire rx_push_bad = rx_push && rx_is_full && !rx_clr;
  wire rx_pop_ok   = rd_rx && !rx_is_mt && !rx_clr;
  wire rx_pop_bad  = rd_rx && rx_is_mt && !rx_clr;

  assign unused_bits = ^host_wdata;
  assign cmd_head  = txm[tx_rp];
  assign cmd_empty = tx_is_mt;
  assign rx_full   = rx_is_full;

  always_ff @(posedge clk) begin
    if (tx_push_ok) txm[tx_wp] <= host_wdata[CMD_W-1:0];
    if (rx_push_ok) rxm[rx_wp] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_n <= '0; tx_rerr <= 1'b0; tx_werr <= 1'b0;
    end else if (tx_clr) begin
      tx_wp <= '0; tx_rp <= '0; tx_n <= '0; tx_rerr <= 1'b0; tx_werr <= 1'b0;
    end else begin
      if (tx_push_ok) tx_wp <= tx_wp + 1'b1;
      if (tx_pop_ok)  tx_rp <= tx_rp + 1'b1;
      tx_n <= tx_n + CW'(tx_push_ok) - CW'(tx_pop_ok);
      if (tx_push_bad) tx_werr <= 1'b1;
      if (tx_pop_bad)  tx_rerr <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_n <= '0; rx_rerr <= 1'b0; rx_werr <= 1'b0;
    end else if (rx_clr) begin
      rx_wp <= '0; rx_rp <= '0; rx_n <= '0; rx_rerr <= 1'b0; rx_werr <= 1'b0;
    end else begin
      if (rx_push_ok) rx_wp <= rx_wp + 1'b1;
      if (rx_pop_ok)  rx_rp <= rx_rp + 1'b1;
      rx_n <= rx_n + CW'(rx_push_ok) - CW'(rx_pop_ok);
      if (rx_push_bad) rx_werr <= 1'b1;
      if (rx_pop_bad)  rx_rerr <= 1'b1;
    end
  end

  assign setv[0] = xfer_done;
  assign setv[1] = xfer_fail;
  assign setv[2] = tx_push_bad || tx_pop_bad || rx_push_bad || rx_pop_bad;
  assign setv[3] = !rx_is_mt && rx_n >= {1'b0, rx_thr};
  assign setv[4] = tx_n <= {1'b0, tx_thr};
  assign clrv = (host_wr && host_addr == A_CLR) ? host_wdata[4:0] : 5'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0; mask <= '0; rx_thr <= '0; tx_thr <= '0;
    end else begin
      pend <= (pend & ~clrv) | setv;
      if (host_wr && host_addr == A_MSK) mask <= host_wdata[4:0];
      if (wr_ctl) begin
        rx_thr <= host_wdata[2 +: AW];
        tx_thr <= host_wdata[8 +: AW];
      end
    end
  end

  assign irq = |(pend & mask);

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      A_RXD: host_rdata[DAT_W-1:0] = rx_is_mt ? '0 : rxm[rx_rp];
      A_CTL: begin
        host_rdata[2 +: AW] = rx_thr;
        host_rdata[8 +: AW] = tx_thr;
      end
      A_STA: begin
        host_rdata[0]  = rx_rerr;
        host_rdata[1]  = rx_werr;
        host_rdata[3]  = rx_is_mt;
        host_rdata[6]  = tx_rerr;
        host_rdata[7]  = tx_werr;
        host_rdata[11] = tx_is_full;
      end
      A_MST: host_rdata[4:0] = pend & mask;
      A_MSK: host_rdata[4:0] = mask;
      default: host_rdata = '0;
    endcase
  end

  AST_TX_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rst_n) tx_n <= FULL_N); // R1
  AST_RX_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rst_n) rx_n <= FULL_N); // R1
  AST_OVERFLOW_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && tx_is_full && !cmd_pop && !tx_clr) |=> (tx_n == FULL_N && tx_werr)); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_werr && !tx_clr) |=> tx_werr); // R5
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clr |=> (cmd_empty && !tx_werr && !tx_rerr)); // R3
  AST_UNDERFLOW_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pop && cmd_empty && !tx_clr) |=> pend[2]); // R8
  AST_W1C_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == A_CLR && host_wdata[0] && !xfer_done) |=> !pend[0]); // R10
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 5'd0) |-> !irq); // R11
endmodule

// File: tb/xfer_queue_pair_test.sv
module xfer_queue_pair_test;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic host_wr = 0, host_rd = 0, cmd_pop = 0, rx_push = 0, xfer_done = 0, xfer_fail = 0;
  logic [3:0] host_addr = 0;
  logic [31:0] host_wdata = 0;
  logic [7:0] rx_byte = 0;
  logic [31:0] host_rdata;
  logic [10:0] cmd_head;
  logic cmd_empty, rx_full, irq;

  xfer_queue_pair uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cmd_pop(cmd_pop), .cmd_head(cmd_head), .cmd_empty(cmd_empty),
    .rx_push(rx_push), .rx_byte(rx_byte), .rx_full(rx_full),
    .xfer_done(xfer_done), .xfer_fail(xfer_fail), .irq(irq)
  );

  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  logic [10:0] mtx[$];
  logic [7:0]  mrx[$];
  int m_rxthr = 0, m_txthr = 0;
  bit m_txr = 0, m_txw = 0, m_rxr = 0, m_rxw = 0;
  logic [4:0] m_pend = 0, m_mask = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rdata();
    logic [31:0] r = 0;
    case (host_addr)
      4'd1: r[7:0] = (mrx.size() == 0) ? 8'd0 : mrx[0];
      4'd2: begin r[7:2] = 6'(m_rxthr); r[13:8] = 6'(m_txthr); end
      4'd3: begin
        r[0] = m_rxr; r[1] = m_rxw; r[3] = (mrx.size() == 0);
        r[6] = m_txr; r[7] = m_txw; r[11] = (mtx.size() == DEPTH);
      end
      4'd4: r[4:0] = m_pend & m_mask;
      4'd6: r[4:0] = m_mask;
      default: r = 0;
    endcase
    return r;
  endfunction

  task automatic compare();
    case (host_addr)
      4'd1: chk("R2 receive word", host_rdata, exp_rdata());
      4'd2: chk("R3 control word", host_rdata, exp_rdata());
      4'd3: chk("R4 status word", host_rdata, exp_rdata());
      4'd4: chk("R9 masked status", host_rdata, exp_rdata());
      4'd6: chk("R9 mask word", host_rdata, exp_rdata());
      default: chk("R4 unmapped word", host_rdata, exp_rdata());
    endcase
    chk("R1 cmd_empty", cmd_empty, mtx.size() == 0);
    chk("R1 rx_full", rx_full, mrx.size() == DEPTH);
    if (mtx.size() > 0) chk("R2 cmd_head", cmd_head, mtx[0]);
    chk("R11 irq", irq, |(m_pend & m_mask));
  endtask

  task automatic model_step();
    bit wc, rdx, ctl, txc, rxc, fault;
    logic [4:0] setv, clrv;
    int n;
    if (!rst_n) begin
      mtx.delete(); mrx.delete(); m_rxthr = 0; m_txthr = 0;
      m_txr = 0; m_txw = 0; m_rxr = 0; m_rxw = 0; m_pend = 0; m_mask = 0;
      return;
    end
    wc  = host_wr && host_addr == 4'd0;
    rdx = host_rd && host_addr == 4'd1;
    ctl = host_wr && host_addr == 4'd2;
    txc = ctl && host_wdata[1];
    rxc = ctl && host_wdata[0];
    fault = 0;
    setv[0] = xfer_done;
    setv[1] = xfer_fail;
    setv[3] = mrx.size() != 0 && mrx.size() >= m_rxthr;   // R6
    setv[4] = mtx.size() <= m_txthr;                      // R7
    if (txc) begin mtx.delete(); m_txr = 0; m_txw = 0; end
    else begin
      n = mtx.size();
      if (cmd_pop && n == 0) begin m_txr = 1; fault = 1; end
      if (wc && n == DEPTH) begin m_txw = 1; fault = 1; end
      if (cmd_pop && n > 0) void'(mtx.pop_front());
      if (wc && n < DEPTH) mtx.push_back(host_wdata[10:0]);
    end
    if (rxc) begin mrx.delete(); m_rxr = 0; m_rxw = 0; end
    else begin
      n = mrx.size();
      if (rdx && n == 0) begin m_rxr = 1; fault = 1; end
      if (rx_push && n == DEPTH) begin m_rxw = 1; fault = 1; end
      if (rdx && n > 0) void'(mrx.pop_front());
      if (rx_push && n < DEPTH) mrx.push_back(rx_byte);
    end
    setv[2] = fault;
    clrv = (host_wr && host_addr == 4'd5) ? host_wdata[4:0] : 5'd0;
    m_pend = (m_pend & ~clrv) | setv;
    if (ctl) begin m_rxthr = int'(host_wdata[7:2]); m_txthr = int'(host_wdata[13:8]); end
    if (host_wr && host_addr == 4'd6) m_mask = host_wdata[4:0];
  endtask

  task automatic idle();
    host_wr = 0; host_rd = 0; cmd_pop = 0; rx_push = 0; xfer_done = 0; xfer_fail = 0;
  endtask

  task automatic tick();
    #1 compare();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic hw(logic [3:0] a, logic [31:0] d);
    host_wr = 1; host_addr = a; host_wdata = d; tick(); idle();
  endtask

  task automatic peek(logic [3:0] a, output logic [31:0] v);
    host_addr = a; #1 v = host_rdata; #1;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired, run did not finish");
      summary();
      $finish;
    end
  end

  logic [31:0] v;
  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    model_step();
    tick();
    peek(4'd3, v); chk("R12 reset status", v, 32'h8);
    peek(4'd2, v); chk("R12 reset thresholds", v, 0);
    chk("R12 reset irq", irq, 0);
    rst_n = 1;
    tick(); tick();
    peek(4'd6, v); chk("R12 reset mask", v, 0);

    hw(4'd6, 32'h1F);
    peek(4'd4, v); chk("R7 low-water pending at level 0", v, 32'h10);
    hw(4'd5, 32'h1F);
    peek(4'd4, v); chk("R10 set wins over clear", v, 32'h10);
    hw(4'd2, (32'd1 << 8) | (32'd4 << 2) | 32'h3);
    peek(4'd2, v); chk("R3 thresholds, clear bits read 0", v, 32'h110);

    hw(4'd0, 32'h5A3); hw(4'd0, 32'h1FF); hw(4'd0, 32'hFFFF_F400);
    chk("R2 first command at head", cmd_head, 11'h5A3);
    cmd_pop = 1; tick(); idle();
    chk("R2 second command at head", cmd_head, 11'h1FF);
    cmd_pop = 1; tick(); tick(); idle();
    chk("R1 queue drained", cmd_empty, 1);

    for (int i = 0; i < DEPTH; i++) hw(4'd0, 32'(i));
    peek(4'd3, v); chk("R4 command full bit", v, 32'h808);
    hw(4'd5, 32'h1F);
    hw(4'd0, 32'h7FF);   // R5 overflow
    peek(4'd3, v); chk("R5 overflow flag", v, 32'h888);
    peek(4'd4, v); chk("R8 queue error pending", v[2], 1);
    cmd_pop = 1; tick(); idle();
    peek(4'd3, v); chk("R5 flag sticky after pop", v, 32'h88);
    chk("R5 head after dropped push", cmd_head, 11'd1);
    hw(4'd2, (32'd1 << 8) | (32'd4 << 2) | 32'h2);
    peek(4'd3, v); chk("R3 command queue emptied", v, 32'h8);
    cmd_pop = 1; tick(); idle();   // R5 underflow
    peek(4'd3, v); chk("R5 underflow flag", v, 32'h48);
    hw(4'd2, (32'd1 << 8) | (32'd4 << 2) | 32'h2);

    hw(4'd5, 32'h1F);
    for (int i = 0; i < 3; i++) begin rx_push = 1; rx_byte = 8'(8'hA0 + i); tick(); end
    idle(); tick();
    peek(4'd4, v); chk("R6 below threshold", v[3], 0);
    rx_push = 1; rx_byte = 8'hA3; tick(); idle(); tick();
    peek(4'd4, v); chk("R6 at threshold", v[3], 1);
    for (int i = 0; i < 4; i++) begin
      host_rd = 1; host_addr = 4'd1; #1 v = host_rdata;
      chk("R2 receive order", v, 32'(8'hA0 + i));
      tick(); idle();
    end
    host_rd = 1; host_addr = 4'd1; tick(); idle();
    peek(4'd3, v); chk("R5 receive underflow flag", v, 32'h9);
    for (int i = 0; i < DEPTH + 1; i++) begin rx_push = 1; rx_byte = 8'(i); tick(); end
    idle();
    chk("R1 rx_full", rx_full, 1);
    peek(4'd3, v); chk("R5 receive overflow flag", v, 32'h3);
    hw(4'd2, (32'd1 << 8) | (32'd4 << 2) | 32'h1);
    peek(4'd3, v); chk("R3 receive queue emptied", v, 32'h8);

    hw(4'd5, 32'h1F);
    hw(4'd6, 32'h1);
    xfer_fail = 1; tick(); idle();
    peek(4'd4, v); chk("R9 failure masked off", v, 0);
    chk("R11 irq low when masked", irq, 0);
    xfer_done = 1; tick(); idle();
    peek(4'd4, v); chk("R8 done pending", v, 1);
    chk("R11 irq raised", irq, 1);
    hw(4'd6, 32'h2);
    peek(4'd4, v); chk("R8 fail pending", v, 2);
    hw(4'd5, 32'h2);
    peek(4'd4, v); chk("R10 cleared", v, 0);
    hw(4'd6, 32'h0);

    for (int c = 0; c < 4000; c++) begin
      int op;
      op = $urandom_range(0, 99);
      host_wdata = $urandom();
      if (op < 35)      begin host_wr = 1; host_addr = 4'd0; end
      else if (op < 60) begin host_rd = 1; host_addr = 4'd1; end
      else if (op < 62) begin host_wr = 1; host_addr = 4'd2; host_wdata[1:0] = 2'($urandom_range(0, 3) == 0 ? $urandom_range(1, 3) : 0); end
      else if (op < 66) begin host_wr = 1; host_addr = 4'd5; end
      else if (op < 68) begin host_wr = 1; host_addr = 4'd6; end
      else begin host_addr = 4'($urandom_range(0, 15)); end
      cmd_pop = ($urandom_range(0, 99) < 30);
      rx_push = ($urandom_range(0, 99) < 35);
      rx_byte = 8'($urandom());
      xfer_done = ($urandom_range(0, 99) < 3);
      xfer_fail = ($urandom_range(0, 99) < 3);
      tick();
      idle();
    end
    tick();
    finished = 1;
    summary();
    $finish;
  end
endmodule